// File: doc/BRIEF.md
# Prescaled 16-bit timer/counter

This block is a 16-bit up-counter that either counts a quarter-rate tick derived from the system clock or counts rising edges on one of two external input pins. A divide-by-1/2/4/8 prescaler sits in front of the counter. When external counting is selected, a control bit chooses between two paths. On the synchronized path, the prescaler output crosses a two-flop synchronizer before it can advance the count. On the direct path, the prescaler output advances the count with no synchronizer.

Software loads the count one byte at a time, reads it back one byte at a time, and programs the mode through a single control byte. A sticky overflow flag records every wrap of the count. A sleep input models a stopped core clock. During sleep, a synchronized external count freezes, but the prescaler keeps accepting edges. After enable, external counting only begins once the input has shown a falling edge.

Top module: `tmr16`

## Requirements
- R1: With control bit 1 (source) at 0 and bit 0 (run) at 1, the count advances once every 4 system clocks times the prescale ratio, counting from the control write. Control bit 2 (direct path) has no effect in this mode.
- R2: Control bits 4:3 select the prescale ratio. Code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. With n qualifying ticks since the prescaler was cleared, the count has advanced floor(n/ratio).
- R3: With the source bit at 1, rising edges of the selected pin are counted only after a falling edge has been seen since the mode was enabled. A rising edge that comes before that first falling edge is ignored.
- R4: Control bit 5 selects the pin: 1 selects ext_b_i and 0 selects ext_a_i. Activity on the other pin has no effect.
- R5: With the source bit at 1 and the direct-path bit at 0, the prescaler output passes through a two-stage synchronizer and a change detector. Each prescaler output then advances the count by exactly one.
- R6: While sleep_i is 1, the synchronized external count holds, the internal-source count holds, and the direct-path external count keeps advancing. The prescaler keeps counting external edges during sleep, so its residue carries over when sleep ends.
- R7: When the count advances from 0xFFFF, it wraps to 0x0000 and ovf_o becomes 1. ovf_o stays at 1 until a flag write with wdata_i[0]=0. A flag write with wdata_i[0]=1 leaves it unchanged.
- R8: With the run bit at 0, the count does not advance.
- R9: wr_lo_i loads wdata_i into count bits 7:0, and wr_hi_i loads wdata_i into count bits 15:8. A count write overrides an advance in the same cycle. A count write or a control write clears the prescaler.
- R10: rdata_o shows count bits 15:8 when rd_hi_i is 1 and count bits 7:0 when rd_hi_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Core clock stopped |
| ext_a_i | input | 1 | External count pin A (pin select 0) |
| ext_b_i | input | 1 | External count pin B (pin select 1) |
| wdata_i | input | 8 | Write data for all write strobes |
| wr_lo_i | input | 1 | Load low count byte |
| wr_hi_i | input | 1 | Load high count byte |
| wr_ctl_i | input | 1 | Load control byte from wdata_i[5:0] |
| wr_flag_i | input | 1 | Flag write; wdata_i[0]=0 clears ovf_o |
| rd_hi_i | input | 1 | Read byte select |
| rdata_o | output | 8 | Selected count byte |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check several properties on every cycle. The count either holds or advances by one per cycle. The count is frozen when the run bit is off, and also in synchronized external mode during sleep. A byte write always lands over a simultaneous advance. A wrap always sets the flag, and the flag is sticky. Other behaviour can only be shown by the bench's scenarios. These scenarios cover the exact divide ratios, the arming by the first falling edge, pin selection, and the prescaler residue that carries across a sleep period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       pin_b;
    logic [1:0] ratio;
    logic       direct;
    logic       ext_src;
    logic       run;
  } tmr_ctl_t;
  localparam int unsigned CTL_W = $bits(tmr_ctl_t);
endpackage

// File: rtl/tmr_edge_arm.sv
module tmr_edge_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_a_i,
  input  logic pin_b_i,
  input  logic sel_b_i,
  input  logic enable_i,
  output logic rise_o
);
  logic pin, pin_q, armed_q;
  assign pin = sel_b_i ? pin_b_i : pin_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pin_q <= pin;
      if (!enable_i)          armed_q <= 1'b0;
      else if (!pin && pin_q) armed_q <= 1'b1;
    end
  end

  // counted only once a falling edge has armed the path
  assign rise_o = enable_i && armed_q && pin && !pin_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               out_o
);
  localparam int unsigned PC_W = (1 << RATIO_W) - 1;
  logic [PC_W-1:0] pcnt_q, mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) mask[i] = (i < int'(ratio_i));
  end

  assign out_o = tick_i && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (clr_i)  pcnt_q <= '0;
    else if (tick_i) pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic pulse_o
);
  logic              tgl_q, last_q;
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else if (pulse_i) tgl_q <= ~tgl_q;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) s_q[0] <= 1'b0;
        else         s_q[0] <= tgl_q;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) s_q[g] <= 1'b0;
        else         s_q[g] <= s_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= s_q[STAGES-1];
  end

  assign pulse_o = s_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/tmr16.sv
module tmr16 #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned RATIO_W     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QDIV        = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_i,
  input  logic               ext_a_i,
  input  logic               ext_b_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic               wr_ctl_i,
  input  logic               wr_flag_i,
  input  logic               rd_hi_i,
  output logic [CNT_W/2-1:0] rdata_o,
  output logic               ovf_o
);
  import tmr_pkg::*;
  localparam int unsigned BYTE_W = CNT_W / 2;
  localparam int unsigned QDIV_W = $clog2(QDIV);

  tmr_ctl_t           ctl_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [QDIV_W-1:0]  q_cnt;
  logic               q_tick, ext_rise, pre_tick, pre_out, sync_path, sync_pulse, inc, wr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (wr_ctl_i) ctl_q <= tmr_ctl_t'(wdata_i[CTL_W-1:0]);
  end

  // quarter-rate internal tick, stopped in sleep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_cnt <= '0;
    else if (wr_ctl_i) q_cnt <= '0;
    else if (ctl_q.run && !ctl_q.ext_src && !sleep_i) q_cnt <= q_cnt + 1'b1;
  end
  assign q_tick = ctl_q.run && !ctl_q.ext_src && !sleep_i && (q_cnt == QDIV_W'(QDIV - 1));

  tmr_edge_arm i_arm (
    .clk_i, .rst_ni,
    .pin_a_i (ext_a_i),
    .pin_b_i (ext_b_i),
    .sel_b_i (ctl_q.pin_b),
    .enable_i(ctl_q.run && ctl_q.ext_src),
    .rise_o  (ext_rise)
  );

  assign wr_cnt   = wr_lo_i || wr_hi_i;
  assign pre_tick = ctl_q.ext_src ? ext_rise : q_tick;

  tmr_prescaler #(.RATIO_W(RATIO_W)) i_pre (
    .clk_i, .rst_ni,
    .clr_i  (wr_cnt || wr_ctl_i),
    .tick_i (pre_tick),
    .ratio_i(ctl_q.ratio),
    .out_o  (pre_out)
  );

  assign sync_path = ctl_q.ext_src && !ctl_q.direct;

  tmr_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni,
    .pulse_i(pre_out && sync_path),
    .pulse_o(sync_pulse)
  );

  assign inc = ctl_q.run && (sync_path ? (sync_pulse && !sleep_i) : pre_out);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_cnt) begin
      if (wr_lo_i) cnt_q[BYTE_W-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_q[CNT_W-1:BYTE_W] <= wdata_i;
    end else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_o <= 1'b0;
    else if (inc && !wr_cnt && (cnt_q == '1)) ovf_o <= 1'b1;
    else if (wr_flag_i && !wdata_i[0])        ovf_o <= 1'b0;
  end

  assign rdata_o = rd_hi_i ? cnt_q[CNT_W-1:BYTE_W] : cnt_q[BYTE_W-1:0];
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CNT_W-1:0]   cnt_i,
  input logic               inc_i,
  input logic               run_i,
  input logic               sync_path_i,
  input logic               sleep_i,
  input logic               wr_lo_i,
  input logic               wr_hi_i,
  input logic               wr_flag_i,
  input logic [CNT_W/2-1:0] wdata_i,
  input logic               ovf_i
);
  // R8
  run_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_i));
  // R6
  sync_sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && sync_path_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_i));
  // R2
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + 1'b1));
  // R9
  lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cnt_i[CNT_W/2-1:0] == $past(wdata_i));
  // R9
  hi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> cnt_i[CNT_W-1:CNT_W/2] == $past(wdata_i));
  // R7
  wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_lo_i && !wr_hi_i && (cnt_i == '1)) |=> (ovf_i && cnt_i == '0));
  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !(wr_flag_i && !wdata_i[0])) |=> ovf_i);
endmodule

bind tmr16 tmr16_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_i      (cnt_q),
  .inc_i      (inc),
  .run_i      (ctl_q.run),
  .sync_path_i(sync_path),
  .sleep_i    (sleep_i),
  .wr_lo_i    (wr_lo_i),
  .wr_hi_i    (wr_hi_i),
  .wr_flag_i  (wr_flag_i),
  .wdata_i    (wdata_i),
  .ovf_i      (ovf_o)
);

// File: tb/test_tmr16.sv
module test_tmr16;
  logic       clk_i = 1'b0, rst_ni = 1'b0, sleep_i = 1'b0;
  logic       ext_a_i = 1'b0, ext_b_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       wr_lo_i = 0, wr_hi_i = 0, wr_ctl_i = 0, wr_flag_i = 0, rd_hi_i = 0;
  logic [7:0] rdata_o;
  logic       ovf_o;
  int         checks = 0, errors = 0;
  bit         done = 0, sel_b = 0;

  always #10 clk_i = ~clk_i;

  tmr16 i_tmr16 (.*);

  function automatic logic [7:0] ctl(bit run, bit ext, bit direct, int code, bit pb);
    return {2'b00, pb, 2'(code), direct, ext, run};
  endfunction
  function automatic int exp_cnt(int ticks, int code);
    return ticks >> code;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic rd(output int v);
    logic [7:0] lo;
    rd_hi_i = 0; #1 lo = rdata_o;
    rd_hi_i = 1; #1 v = {rdata_o, lo};
    rd_hi_i = 0;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(int kind, logic [7:0] d);
    wdata_i = d;
    case (kind)
      0: wr_lo_i = 1; 1: wr_hi_i = 1; 2: wr_ctl_i = 1; default: wr_flag_i = 1;
    endcase
    @(negedge clk_i);
    {wr_lo_i, wr_hi_i, wr_ctl_i, wr_flag_i} = '0;
  endtask

  task automatic set_pin(bit v);
    if (sel_b) begin ext_b_i = v; ext_a_i = 1'($urandom); end
    else       begin ext_a_i = v; ext_b_i = 1'($urandom); end
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      set_pin(1); repeat (3) @(negedge clk_i);
      set_pin(0); repeat (3) @(negedge clk_i);
    end
    repeat (8) @(negedge clk_i);
  endtask

  task automatic setup(logic [7:0] c, logic [15:0] start, bit pre_high);
    wr(2, 8'h00); wr(0, start[7:0]); wr(1, start[15:8]);
    sel_b = c[5];
    ext_a_i = pre_high; ext_b_i = pre_high;
    repeat (2) @(negedge clk_i);
    wr(2, c);
    if (pre_high) begin set_pin(0); repeat (3) @(negedge clk_i); end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    rd(v); chk("R10 reset count", v, 0);
    chk("R7 reset flag", ovf_o, 0);

    // R1 R2: internal source, all ratios, exact boundary
    for (int code = 0; code < 4; code++) begin
      setup(ctl(1, 0, code[0], code, 0), 16'h0, 0);
      repeat (4 * 3 * (1 << code) - 1) @(negedge clk_i);
      rd(v); chk("R1 internal before boundary", v, 2);
      @(negedge clk_i);
      rd(v); chk("R2 internal at boundary", v, 3);
    end

    // R6: internal source frozen in sleep
    setup(ctl(1, 0, 0, 0, 0), 16'h0, 0);
    sleep_i = 1; repeat (40) @(negedge clk_i); sleep_i = 0;
    rd(v); chk("R6 internal sleep hold", v, 0);

    // R9: write over simultaneous increment, then next tick
    setup(ctl(1, 0, 0, 0, 0), 16'h0, 0);
    repeat (3) @(negedge clk_i);
    wr(0, 8'h10);
    rd(v); chk("R9 write priority", v, 16'h0010);
    repeat (4) @(negedge clk_i);
    rd(v); chk("R9 increment after write", v, 16'h0011);

    // R7: wrap and sticky flag
    setup(ctl(1, 0, 0, 0, 0), 16'hFFFE, 0);
    repeat (8) @(negedge clk_i);
    rd(v); chk("R7 wrap count", v, 0);
    chk("R7 flag set", ovf_o, 1);
    wr(2, 8'h00);
    wr(3, 8'h01); chk("R7 write 1 keeps flag", ovf_o, 1);
    wr(3, 8'h00); chk("R7 write 0 clears flag", ovf_o, 0);

    // R3: enabled while pin low, first rise ignored
    setup(ctl(1, 1, 1, 0, 0), 16'h0, 0);
    pulses(5);
    rd(v); chk("R3 first rise ignored", v, 4);
    setup(ctl(1, 1, 0, 0, 1), 16'h0, 0);
    pulses(3);
    rd(v); chk("R3 sync first rise ignored", v, 2);

    // R8: run off
    setup(ctl(0, 1, 1, 0, 0), 16'h0, 1);
    pulses(6);
    rd(v); chk("R8 run off holds", v, 0);

    // R4: activity on the unselected pin only
    setup(ctl(1, 1, 1, 0, 1), 16'h0, 1);
    for (int i = 0; i < 6; i++) begin
      ext_a_i = 1; repeat (3) @(negedge clk_i);
      ext_a_i = 0; repeat (3) @(negedge clk_i);
    end
    rd(v); chk("R4 other pin ignored", v, 0);

    // R6 R5: synchronized mode across sleep, ratio 2
    setup(ctl(1, 1, 0, 1, 0), 16'h0, 1);
    pulses(2);
    rd(v); chk("R5 sync before sleep", v, 1);
    sleep_i = 1; pulses(3);
    rd(v); chk("R6 sync holds in sleep", v, 1);
    sleep_i = 0; repeat (8) @(negedge clk_i);
    pulses(1);
    rd(v); chk("R6 prescaler kept counting", v, 2);

    // R6: direct path counts during sleep
    setup(ctl(1, 1, 1, 0, 1), 16'h0, 1);
    sleep_i = 1; pulses(4); sleep_i = 0;
    rd(v); chk("R6 direct counts in sleep", v, 4);

    // R2 R4 R5: random external scenarios
    for (int it = 0; it < 24; it++) begin
      int code = int'($urandom_range(3, 0));
      bit dir = 1'($urandom), pb = 1'($urandom);
      int n = int'($urandom_range(20, 0));
      setup(ctl(1, 1, dir, code, pb), 16'h0, 1);
      pulses(n);
      rd(v); chk(dir ? "R2 random direct" : "R5 random sync", v, exp_cnt(n, code));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule